// File: doc/BRIEF.md
# Stereo Silence Detector

This block watches a stereo stream of signed samples that arrive on a strobe. For each channel it keeps a count of how many zero-valued samples have arrived in an unbroken run. When that count reaches a run length chosen by a 2-bit code, the channel's quiet flag is raised. A global enable turns detection on. Clearing the enable empties both runs and lowers both flags.

The flags only report. The samples also pass through a one-cycle registered output stage, and the flags never change that stage. A single inversion control negates both channels together. Negation saturates, so the most negative code maps to the largest positive code.

Top module: `silence_watch`

## Requirements
- R1: After reset, both quiet flags, the output strobe and both output samples are 0.
- R2: While enabled, each strobed sample equal to zero adds one to that channel's run. The flag rises on the strobe at which the run reaches the selected length. Codes 0, 1, 2 and 3 select RUN_0, RUN_1, RUN_2 and RUN_3 (by default 3200, 4800, 9600 and 19200 samples).
- R3: A strobed non-zero sample clears that channel's run and lowers its flag on the same clock edge.
- R4: The two channels are independent. A sample on one channel never changes the other channel's run or flag.
- R5: With the enable low, both runs are cleared and both flags read 0 from the next clock edge. Strobed samples are not counted.
- R6: Runs saturate at the selected length, so the flag stays high through an arbitrarily long zero run.
- R7: In cycles without a strobe, the runs, the flags and the output samples hold their values, and the output strobe is 0.
- R8: One clock after a strobe, the output strobe is high for one cycle. With inversion off, each output sample equals its input sample.
- R9: With inversion on, both output samples are the two's-complement negation of their inputs. The most negative input code becomes the most positive code.
- R10: The audio outputs do not depend on the enable or on the flags.
- R11: The flag is compared against the currently selected length on every clock. Lowering the code to at or below the current run raises the flag on the next clock without a strobe. Raising it above the run lowers the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Detection enable |
| thr_sel | input | 2 | Run-length code |
| inv_pol | input | 1 | Negate both output channels |
| smp_stb | input | 1 | Sample strobe |
| smp_l | input | DATA_W | Left sample, signed |
| smp_r | input | DATA_W | Right sample, signed |
| out_stb | output | 1 | Output sample strobe |
| out_l | output | DATA_W | Left output sample |
| out_r | output | DATA_W | Right output sample |
| quiet_l | output | 1 | Left silence flag |
| quiet_r | output | 1 | Right silence flag |

## Verification
The bench builds the block with DATA_W = 4 and run lengths of 3, 5, 8 and 12. The 4-bit width lets the polarity sweep cover every sample code on both channels, including the saturating most-negative case, with the detector both on and off. The short runs let every length code be driven past its limit into saturation, and let a threshold change land in the middle of a run, within a few hundred strobes.

// File: rtl/silence_pkg.sv
package silence_pkg;

    typedef enum logic [1:0] {
        THR_SHORT = 2'd0,
        THR_MID   = 2'd1,
        THR_LONG  = 2'd2,
        THR_MAX   = 2'd3
    } thr_code_e;

    // Map a run-length code onto one of four configured lengths.
    function automatic int run_for_code(
        input thr_code_e code,
        input int        len0,
        input int        len1,
        input int        len2,
        input int        len3
    );
        case (code)
            THR_SHORT: return len0;
            THR_MID:   return len1;
            THR_LONG:  return len2;
            default:   return len3;
        endcase
    endfunction

endpackage

// File: rtl/zero_run_ctr.sv
module zero_run_ctr #(
    parameter int DATA_W  = 24,
    parameter int MAX_RUN = 19200,
    parameter int CNT_W   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              stb,
    input  logic [DATA_W-1:0] smp,
    input  logic [CNT_W-1:0]  run_len,
    output logic              flag_o
);

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_RUN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else begin
            if (stb) begin
                if (smp == '0) begin
                    // saturate at the selected length (also clamps after a lowered code)
                    st_d.cnt = (st_q.cnt >= run_len) ? run_len : st_q.cnt + 1'b1;
                end else begin
                    st_d.cnt = '0;
                end
            end
            // compared against the live length every cycle
            st_d.flag = (st_d.cnt >= run_len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R3: a non-zero strobed sample empties the run and drops the flag
    a_r3_nonzero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stb && smp != '0) |=> (!flag_o && st_q.cnt == '0));

    // R5: disabled detector reads quiet-low on the next edge
    a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!flag_o && st_q.cnt == '0));

    // R6: the run never exceeds the longest configured length
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= MAX_CNT);

    // R2: the zero that completes a run raises the flag
    a_r2_flag_on_reach: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stb && smp == '0 && ({1'b0, st_q.cnt} + 1'b1) >= {1'b0, run_len})
        |=> flag_o);

    // R7: without a strobe the run holds
    a_r7_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !stb && st_q.cnt <= run_len) |=> st_q.cnt == $past(st_q.cnt));

endmodule

// File: rtl/polarity_stage.sv
module polarity_stage #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              inv,
    input  logic [DATA_W-1:0] in_l,
    input  logic [DATA_W-1:0] in_r,
    output logic              out_stb,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r
);

    localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MAX_V = ~MIN_V;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] l;
        logic [DATA_W-1:0] r;
    } pol_st_t;

    pol_st_t st_d, st_q;

    function automatic logic [DATA_W-1:0] flip(
        input logic [DATA_W-1:0] x,
        input logic              neg
    );
        if (!neg)       return x;
        if (x == MIN_V) return MAX_V;
        return ~x + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.vld = stb;
        if (stb) begin
            st_d.l = flip(in_l, inv);
            st_d.r = flip(in_r, inv);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_stb = st_q.vld;
    assign out_l   = st_q.l;
    assign out_r   = st_q.r;

    // R8: output strobe follows the input strobe by one cycle
    a_r8_stb_delay: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> out_stb);

    // R8: straight pass with inversion off
    a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !inv) |=> (out_l == $past(in_l) && out_r == $past(in_r)));

    // R9: inverted output sums with its input to zero
    a_r9_negate: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && inv && in_l != MIN_V) |=> ((out_l + $past(in_l)) == '0));

    // R9: most negative code saturates
    a_r9_min_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && inv && in_l == MIN_V) |=> out_l == MAX_V);

    // R7: idle cycles hold the audio and keep the strobe low
    a_r7_audio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> (!out_stb && $stable(out_l) && $stable(out_r)));

endmodule

// File: rtl/silence_watch.sv
module silence_watch
    import silence_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int RUN_0  = 3200,
    parameter int RUN_1  = 4800,
    parameter int RUN_2  = 9600,
    parameter int RUN_3  = 19200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_en,
    input  logic [1:0]        thr_sel,
    input  logic              inv_pol,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] smp_l,
    input  logic [DATA_W-1:0] smp_r,
    output logic              out_stb,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r,
    output logic              quiet_l,
    output logic              quiet_r
);

    localparam int MAX_01  = (RUN_0 > RUN_1) ? RUN_0 : RUN_1;
    localparam int MAX_23  = (RUN_2 > RUN_3) ? RUN_2 : RUN_3;
    localparam int MAX_RUN = (MAX_01 > MAX_23) ? MAX_01 : MAX_23;
    localparam int CNT_W   = $clog2(MAX_RUN + 1);
    localparam int N_CH    = 2;

    logic [CNT_W-1:0]  run_len;
    logic [DATA_W-1:0] ch_smp [N_CH];
    logic [N_CH-1:0]   ch_flag;

    always_comb begin
        run_len = CNT_W'(run_for_code(thr_code_e'(thr_sel), RUN_0, RUN_1, RUN_2, RUN_3));
    end

    assign ch_smp[0] = smp_l;
    assign ch_smp[1] = smp_r;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        zero_run_ctr #(
            .DATA_W  (DATA_W),
            .MAX_RUN (MAX_RUN),
            .CNT_W   (CNT_W)
        ) u_run (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (det_en),
            .stb     (smp_stb),
            .smp     (ch_smp[g]),
            .run_len (run_len),
            .flag_o  (ch_flag[g])
        );
    end

    polarity_stage #(
        .DATA_W (DATA_W)
    ) u_pol (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (smp_stb),
        .inv     (inv_pol),
        .in_l    (smp_l),
        .in_r    (smp_r),
        .out_stb (out_stb),
        .out_l   (out_l),
        .out_r   (out_r)
    );

    assign quiet_l = ch_flag[0];
    assign quiet_r = ch_flag[1];

    // R4: a non-zero on one channel leaves a set flag on the other untouched when it also sees zero
    a_r4_left_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && smp_stb && smp_l == '0 && smp_r != '0 && quiet_l && $stable(thr_sel))
        |=> (quiet_l && !quiet_r));

endmodule

// File: tb/silence_watch_bench.sv
`timescale 1ns/1ps
module silence_watch_bench;

    localparam int W = 4;
    localparam int RL [4] = '{3, 5, 8, 12};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         det_en = 1'b0;
    logic [1:0]   thr_sel = 2'd0;
    logic         inv_pol = 1'b0;
    logic         smp_stb = 1'b0;
    logic [W-1:0] smp_l = '0;
    logic [W-1:0] smp_r = '0;
    logic         out_stb;
    logic [W-1:0] out_l, out_r;
    logic         quiet_l, quiet_r;

    int total = 0;
    int bad   = 0;
    int cl = 0;
    int cr = 0;

    always #2 clk = ~clk;

    silence_watch #(
        .DATA_W (W), .RUN_0 (3), .RUN_1 (5), .RUN_2 (8), .RUN_3 (12)
    ) u_silence_watch (
        .clk (clk), .rst_n (rst_n), .det_en (det_en), .thr_sel (thr_sel),
        .inv_pol (inv_pol), .smp_stb (smp_stb), .smp_l (smp_l), .smp_r (smp_r),
        .out_stb (out_stb), .out_l (out_l), .out_r (out_r),
        .quiet_l (quiet_l), .quiet_r (quiet_r)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_out(input int v, input logic neg);
        if (!neg) return v;
        if (v == 8) return 7;
        return (16 - v) & 15;
    endfunction

    function automatic int step(input int c, input int v);
        int len = RL[thr_sel];
        if (v != 0) return 0;
        return (c >= len) ? len : c + 1;
    endfunction

    // drive one strobed sample pair and check all outputs after the edge
    task automatic strobe(input string req, input int l, input int r);
        @(negedge clk);
        smp_stb = 1'b1;
        smp_l = W'(l);
        smp_r = W'(r);
        if (det_en) begin
            cl = step(cl, l);
            cr = step(cr, r);
        end else begin
            cl = 0;
            cr = 0;
        end
        @(negedge clk);
        smp_stb = 1'b0;
        chk({req, " quiet_l"}, int'(quiet_l), int'(det_en && cl >= RL[thr_sel]));
        chk({req, " quiet_r"}, int'(quiet_r), int'(det_en && cr >= RL[thr_sel]));
        chk({req, " out_stb"}, int'(out_stb), 1);
        chk({req, " out_l"}, int'(out_l), exp_out(l, inv_pol));
        chk({req, " out_r"}, int'(out_r), exp_out(r, inv_pol));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 quiet_l", int'(quiet_l), 0);
        chk("R1 quiet_r", int'(quiet_r), 0);
        chk("R1 out_stb", int'(out_stb), 0);
        chk("R1 out_l", int'(out_l), 0);
        chk("R1 out_r", int'(out_r), 0);
        rst_n = 1'b1;
        @(negedge clk);
        det_en = 1'b1;
        @(negedge clk);

        // R2 / R6: every code, driven past its length into saturation
        for (int code = 0; code < 4; code++) begin
            thr_sel = 2'(code);
            strobe("R3 clear", 1, 1);
            for (int k = 0; k < RL[code] + 4; k++) begin
                strobe((k < RL[code]) ? "R2 run" : "R6 sat", 0, 0);
            end
        end

        // R3 / R4: one channel breaks its run, the other keeps it
        thr_sel = 2'd0;
        @(negedge clk);
        strobe("R4 left kept", 0, 5);
        strobe("R4 right kept", 3, 0);
        for (int k = 0; k < 4; k++) strobe("R4 build", 0, 0);
        strobe("R3 both", 7, 9);

        // R7: idle cycles hold state
        for (int k = 0; k < 4; k++) strobe("R2 rebuild", 0, 0);
        repeat (5) begin
            @(negedge clk);
            chk("R7 quiet_l", int'(quiet_l), 1);
            chk("R7 quiet_r", int'(quiet_r), 1);
            chk("R7 out_stb", int'(out_stb), 0);
            chk("R7 out_l", int'(out_l), 0);
        end

        // R5: disable clears, zeros not counted while off
        det_en = 1'b0;
        cl = 0;
        cr = 0;
        @(negedge clk);
        chk("R5 quiet_l", int'(quiet_l), 0);
        chk("R5 quiet_r", int'(quiet_r), 0);
        for (int k = 0; k < 5; k++) strobe("R5 off", 0, 0);
        det_en = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) strobe("R5 restart", 0, 0);

        // R8 / R9 / R10: every code, both polarities, detector on and off
        for (int e = 0; e < 2; e++) begin
            det_en = e[0];
            for (int p = 0; p < 2; p++) begin
                inv_pol = p[0];
                for (int v = 0; v < 16; v++) begin
                    strobe(p ? "R9 invert" : (e ? "R8 pass" : "R10 off pass"), v, (v * 5 + 3) & 15);
                end
            end
        end
        inv_pol = 1'b0;

        // R11: live length change mid-run
        det_en = 1'b1;
        thr_sel = 2'd3;
        @(negedge clk);
        strobe("R11 clear", 2, 2);
        for (int k = 0; k < 8; k++) strobe("R11 build", 0, 0);
        thr_sel = 2'd2;
        @(negedge clk);
        chk("R11 lowered", int'(quiet_l), 1);
        thr_sel = 2'd3;
        @(negedge clk);
        chk("R11 raised", int'(quiet_r), 0);
        for (int k = 0; k < 4; k++) strobe("R11 finish", 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule